// File: doc/BRIEF.md
# Interrupt Status and Soft-Reset Unit

This unit collects single-cycle event pulses from the rest of a storage-card host controller into a sticky 32-bit status register and qualifies them with a 32-bit enable register to drive one level-sensitive interrupt line. Software reads the status, then acknowledges events by writing ones to the bits it has handled. Every host write carries a 4-bit byte-lane mask, and only the selected lanes take part.

The unit also holds a clock/timeout control word. Its top byte is a write-only soft-reset command byte. One command returns every register in the unit to its reset value. The other two each wipe only the status bits that belong to the command path or to the data path. A small DMA fault register, loaded by the DMA engine, is cleared by the data-path reset. A 256-byte window at the top of the address space is reserved: it reads as zero and ignores writes. A signal-enable location is present but is not implemented.

Top module: `irq_status_unit`

## Requirements
- R1: `irqOut` is high in every cycle in which at least one bit is set in both the status register (address 0x000) and the enable register (address 0x004), and low otherwise.
- R2: A one on `evtSet[i]` sets status bit i at the next clock edge. Status bits named in the design are: 0 command done, 1 transfer done, 3 DMA boundary, 4 write space ready, 5 read data ready, 15 error summary, 16 command timeout, 25 descriptor-DMA fault. When a set pulse and any clear (host write or soft reset) hit the same bit in the same cycle, the bit ends up set.
- R3: A write to the status register clears each bit whose write data is one and whose byte lane is enabled (byte-enable bit n covers data bits 8n+7..8n). All other status bits keep their value.
- R4: A write to the enable register replaces only the enabled byte lanes: new = (old & ~laneMask) | (data & laneMask).
- R5: Writing the control word (address 0x00C) with lane 3 enabled and data bit 24 set resets status, enable and the fault register to zero and returns the control word to 0x0000_0002.
- R6: Control-word data bit 25, with lane 3 enabled, clears status bit 0 only.
- R7: Control-word data bit 26, with lane 3 enabled, clears status bits 1 and 3 and the fault register. With lane 3 disabled, bits 31..24 of the write have no effect.
- R8: Bits 23..0 of the control word are read/write under byte lanes, bit 1 always reads one (after reset and after every write), and bits 31..24 always read zero.
- R9: Addresses 0x100 to 0x1FF read as zero and any write there changes no register.
- R10: The signal-enable location (address 0x008) always reads zero, and writes to it have no effect.
- R11: The fault register (address 0x010, bits 7..0, upper bits read zero) loads `dmaFaultCode` when `dmaFaultValid` is high. A load in the same cycle as a data-path reset wins. The register cannot be written by the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe for one cycle |
| regAddr | input | 9 | Byte address of the register access |
| regByteEn | input | 4 | Byte-lane mask for writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for `regAddr`, combinational, no side effects |
| evtSet | input | 32 | Per-bit event pulses that set status bits |
| dmaFaultValid | input | 1 | Load strobe for the fault register |
| dmaFaultCode | input | 8 | Fault code to load |
| irqOut | output | 1 | Level interrupt request |

## Verification
Status writes are tried with different lane masks over a register that has bits in several lanes set at once. This shows whether clearing is gated by lane and by data, and not applied to the whole word. Each of the three soft-reset commands is issued while status bits from both the command group and the data group are set, so a reset that clears the wrong group shows up. A set pulse and a clear of the same bit are driven in the same cycle to settle the priority. The reserved window is written at an offset whose low bits alias the enable register, which exposes a partial address decode.

// File: rtl/irqs_pkg.sv
package irqs_pkg;
  localparam int DATA_W  = 32;
  localparam int LANES   = DATA_W / 8;
  localparam int ADDR_W  = 9;
  localparam int FAULT_W = 8;
  localparam int CTRL_W  = 24;

  localparam logic [ADDR_W-1:0] ADDR_STAT  = 9'h000;
  localparam logic [ADDR_W-1:0] ADDR_ENAB  = 9'h004;
  localparam logic [ADDR_W-1:0] ADDR_SIGEN = 9'h008;
  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 9'h00C;
  localparam logic [ADDR_W-1:0] ADDR_FAULT = 9'h010;

  // Status bit positions
  localparam int BIT_CMD_DONE   = 0;
  localparam int BIT_XFER_DONE  = 1;
  localparam int BIT_DMA_BOUND  = 3;
  localparam int BIT_WR_SPACE   = 4;
  localparam int BIT_RD_READY   = 5;
  localparam int BIT_ERR_SUM    = 15;
  localparam int BIT_CMD_TMO    = 16;
  localparam int BIT_DESC_FAULT = 25;

  // Soft-reset command bits inside the control word
  localparam int RST_ALL_BIT  = 24;
  localparam int RST_CMD_BIT  = 25;
  localparam int RST_DATA_BIT = 26;

  localparam logic [CTRL_W-1:0] CTRL_RESET_VAL = 24'h000002;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_STAT, SEL_ENAB, SEL_CTRL, SEL_FAULT
  } readSel_e;

  typedef struct packed {
    logic              wrStat;
    logic              wrEnab;
    logic              wrCtrl;
    logic              rstAll;
    logic              rstCmd;
    logic              rstData;
    logic              vendorWr;
    logic [DATA_W-1:0] laneMask;
    readSel_e          rdSel;
  } ctrlStrb_t;
endpackage

// File: rtl/irqs_ctrl.sv
module irqs_ctrl
  import irqs_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [LANES-1:0]  regByteEn,
  input  logic [DATA_W-1:0] regWrData,
  output ctrlStrb_t         strb
);
  logic [DATA_W-1:0] laneMask;
  logic inVendor;
  logic ctrlHit;

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    assign laneMask[8*ln +: 8] = {8{regByteEn[ln]}};
  end

  assign inVendor = regAddr[ADDR_W-1];
  assign ctrlHit  = regWrEn && !inVendor && (regAddr == ADDR_CTRL);

  always_comb begin
    strb          = '0;
    strb.laneMask = laneMask;
    strb.vendorWr = regWrEn && inVendor;
    strb.wrStat   = regWrEn && !inVendor && (regAddr == ADDR_STAT);
    strb.wrEnab   = regWrEn && !inVendor && (regAddr == ADDR_ENAB);
    strb.wrCtrl   = ctrlHit;
    strb.rstAll   = ctrlHit && regByteEn[LANES-1] && regWrData[RST_ALL_BIT];
    strb.rstCmd   = ctrlHit && regByteEn[LANES-1] && regWrData[RST_CMD_BIT];
    strb.rstData  = ctrlHit && regByteEn[LANES-1] && regWrData[RST_DATA_BIT];
    strb.rdSel    = SEL_NONE;
    if (!inVendor) begin
      case (regAddr)
        ADDR_STAT:  strb.rdSel = SEL_STAT;
        ADDR_ENAB:  strb.rdSel = SEL_ENAB;
        ADDR_CTRL:  strb.rdSel = SEL_CTRL;
        ADDR_FAULT: strb.rdSel = SEL_FAULT;
        default:    strb.rdSel = SEL_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irqs_datapath.sv
module irqs_datapath
  import irqs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [DATA_W-1:0]  evtSet,
  input  logic               dmaFaultValid,
  input  logic [FAULT_W-1:0] dmaFaultCode,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  logic [DATA_W-1:0]  statusQ, enableQ, clrMask;
  logic [CTRL_W-1:0]  ctrlQ;
  logic [FAULT_W-1:0] faultQ;
  logic [DATA_W-1:0]  dataMask;

  assign dataMask = regWrData & strb.laneMask;

  always_comb begin
    clrMask = '0;
    if (strb.wrStat) clrMask = dataMask;
    if (strb.rstCmd) clrMask[BIT_CMD_DONE] = 1'b1;
    if (strb.rstData) begin
      clrMask[BIT_XFER_DONE] = 1'b1;
      clrMask[BIT_DMA_BOUND] = 1'b1;
    end
    if (strb.rstAll) clrMask = '1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      enableQ <= '0;
      ctrlQ   <= CTRL_RESET_VAL;
      faultQ  <= '0;
    end else begin
      statusQ <= (statusQ & ~clrMask) | evtSet;
      if (strb.rstAll)
        enableQ <= '0;
      else if (strb.wrEnab)
        enableQ <= (enableQ & ~strb.laneMask) | dataMask;
      if (strb.rstAll)
        ctrlQ <= CTRL_RESET_VAL;
      else if (strb.wrCtrl)
        ctrlQ <= ((ctrlQ & ~strb.laneMask[CTRL_W-1:0]) | dataMask[CTRL_W-1:0])
                 | CTRL_RESET_VAL;
      if (dmaFaultValid)
        faultQ <= dmaFaultCode;
      else if (strb.rstAll || strb.rstData)
        faultQ <= '0;
    end
  end

  always_comb begin
    case (strb.rdSel)
      SEL_STAT:  regRdData = statusQ;
      SEL_ENAB:  regRdData = enableQ;
      SEL_CTRL:  regRdData = {{(DATA_W-CTRL_W){1'b0}}, ctrlQ};
      SEL_FAULT: regRdData = {{(DATA_W-FAULT_W){1'b0}}, faultQ};
      default:   regRdData = '0;
    endcase
  end

  assign irqOut = |(statusQ & enableQ);

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|evtSet) |=> ((statusQ & $past(evtSet)) == $past(evtSet)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrStat && !(|evtSet)) |=> ((statusQ & $past(dataMask)) == '0));

  // R6
  cmd_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rstCmd && !evtSet[BIT_CMD_DONE]) |=> !statusQ[BIT_CMD_DONE]);

  // R7
  data_reset_fault_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rstData && !dmaFaultValid) |=> (faultQ == '0));

  // R8
  clk_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCtrl |=> ctrlQ[1]);

  // R9
  vendor_ignore_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.vendorWr |=> ($stable(enableQ) && $stable(ctrlQ)));
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irqs_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [LANES-1:0]   regByteEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [DATA_W-1:0]  evtSet,
  input  logic               dmaFaultValid,
  input  logic [FAULT_W-1:0] dmaFaultCode,
  output logic               irqOut
);
  ctrlStrb_t strb;

  irqs_ctrl ctrl_i (
    .regWrEn   (regWrEn),
    .regAddr   (regAddr),
    .regByteEn (regByteEn),
    .regWrData (regWrData),
    .strb      (strb)
  );

  irqs_datapath dp_i (
    .clk           (clk),
    .rstN          (rstN),
    .strb          (strb),
    .regWrData     (regWrData),
    .evtSet        (evtSet),
    .dmaFaultValid (dmaFaultValid),
    .dmaFaultCode  (dmaFaultCode),
    .regRdData     (regRdData),
    .irqOut        (irqOut)
  );
endmodule

// File: tb/irq_status_unit_tb.sv
module irq_status_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [8:0]  regAddr = '0;
  logic [3:0]  regByteEn = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] evtSet = '0;
  logic        dmaFaultValid = 1'b0;
  logic [7:0]  dmaFaultCode = '0;
  logic        irqOut;

  int checks = 0;
  int errors = 0;
  logic probe = 1'b0;
  logic done = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } expItem_t;
  expItem_t sbQ[$];

  always #5 clk = ~clk;

  irq_status_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regByteEn(regByteEn), .regWrData(regWrData), .regRdData(regRdData),
    .evtSet(evtSet), .dmaFaultValid(dmaFaultValid),
    .dmaFaultCode(dmaFaultCode), .irqOut(irqOut)
  );

  // Monitor: pops one expected item per probe cycle
  always @(negedge clk) begin
    if (probe && sbQ.size() > 0) begin
      expItem_t it;
      logic [31:0] act;
      it = sbQ.pop_front();
      act = it.isIrq ? {31'b0, irqOut} : regRdData;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step(input logic we, input logic [8:0] a, input logic [31:0] d,
                      input logic [3:0] be, input logic [31:0] ev,
                      input logic fv, input logic [7:0] fc);
    @(posedge clk); #1;
    regWrEn = we; regAddr = a; regWrData = d; regByteEn = be;
    evtSet = ev; dmaFaultValid = fv; dmaFaultCode = fc;
    @(posedge clk); #1;
    regWrEn = 0; evtSet = '0; dmaFaultValid = 0;
  endtask

  task automatic wr(input logic [8:0] a, input logic [31:0] d, input logic [3:0] be);
    step(1'b1, a, d, be, '0, 1'b0, '0);
  endtask

  task automatic pulse(input logic [31:0] ev);
    step(1'b0, '0, '0, '0, ev, 1'b0, '0);
  endtask

  task automatic expectRd(input logic [8:0] a, input logic [31:0] e, input string tag);
    @(posedge clk); #1;
    regAddr = a;
    sbQ.push_back('{isIrq: 1'b0, exp: e, tag: tag});
    probe = 1;
    @(posedge clk); #1;
    probe = 0;
  endtask

  task automatic expectIrq(input logic e, input string tag);
    @(posedge clk); #1;
    sbQ.push_back('{isIrq: 1'b1, exp: {31'b0, e}, tag: tag});
    probe = 1;
    @(posedge clk); #1;
    probe = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // reset state
    expectRd(9'h000, 32'h0, "R2 status after reset");
    expectRd(9'h004, 32'h0, "R4 enable after reset");
    expectRd(9'h00C, 32'h2, "R8 control word after reset");
    expectIrq(1'b0, "R1 idle after reset");
    // events set bits, no irq while disabled
    pulse(32'h0201_0001);
    expectRd(9'h000, 32'h0201_0001, "R2 events set status");
    expectIrq(1'b0, "R1 masked by enable");
    wr(9'h004, 32'h0000_0001, 4'b1111);
    expectIrq(1'b1, "R1 enabled bit raises irq");
    // lane-masked enable write
    wr(9'h004, 32'hFFFF_FFFF, 4'b0011);
    expectRd(9'h004, 32'h0000_FFFF, "R4 enable lanes 0-1 only");
    // lane-masked w1c
    wr(9'h000, 32'hFFFF_FFFF, 4'b0001);
    expectRd(9'h000, 32'h0201_0000, "R3 clear lane 0 only");
    expectIrq(1'b0, "R1 drops after clear");
    wr(9'h000, 32'hFFFF_FFFF, 4'b1100);
    expectRd(9'h000, 32'h0, "R3 clear upper lanes");
    // set wins over clear in the same cycle
    step(1'b1, 9'h000, 32'h0000_0010, 4'b1111, 32'h0000_0010, 1'b0, '0);
    expectRd(9'h000, 32'h0000_0010, "R2 set wins over clear");
    expectIrq(1'b1, "R1 bit 4 enabled");
    // command and data resets
    pulse(32'h0000_003B);
    step(1'b0, '0, '0, '0, '0, 1'b1, 8'h05);
    expectRd(9'h010, 32'h0000_0005, "R11 fault loaded");
    wr(9'h010, 32'hFFFF_FFFF, 4'b1111);
    expectRd(9'h010, 32'h0000_0005, "R11 fault not host writable");
    wr(9'h00C, 32'h0400_0000, 4'b0111);
    expectRd(9'h000, 32'h0000_003B, "R7 reset byte ignored without lane 3");
    wr(9'h00C, 32'h0200_0000, 4'b1000);
    expectRd(9'h000, 32'h0000_003A, "R6 command reset clears bit 0 only");
    wr(9'h00C, 32'h0400_0000, 4'b1000);
    expectRd(9'h000, 32'h0000_0030, "R7 data reset clears bits 1 and 3");
    expectRd(9'h010, 32'h0, "R7 data reset clears fault");
    // control word
    wr(9'h00C, 32'hFFAB_1234, 4'b0111);
    expectRd(9'h00C, 32'h00AB_1236, "R8 stable bit and zero top byte");
    // reserved window aliasing enable offset
    wr(9'h104, 32'h0, 4'b1111);
    expectRd(9'h004, 32'h0000_FFFF, "R9 vendor write ignored");
    expectRd(9'h104, 32'h0, "R9 vendor read zero");
    wr(9'h008, 32'hFFFF_FFFF, 4'b1111);
    expectRd(9'h008, 32'h0, "R10 signal enable reads zero");
    expectIrq(1'b1, "R1 still pending");
    // full reset
    step(1'b0, '0, '0, '0, '0, 1'b1, 8'h07);
    wr(9'h00C, 32'h0100_0000, 4'b1000);
    expectRd(9'h000, 32'h0, "R5 status cleared");
    expectRd(9'h004, 32'h0, "R5 enable cleared");
    expectRd(9'h00C, 32'h2, "R5 control word restored");
    expectRd(9'h010, 32'h0, "R5 fault cleared");
    expectIrq(1'b0, "R5 irq low after full reset");
    repeat (2) @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule